// File: doc/BRIEF.md
# Periodic Host Channel Request Scheduler

This block is the periodic-transfer side of a full-speed USB host channel controller. Software programs a channel through a single enable strobe. The strobe carries a channel index, an endpoint number, a direction bit, a frame-parity select and a packets-per-frame count. Each strobe appends one request to a four-entry periodic request queue. The block keeps an 11-bit frame counter that advances on every start-of-frame pulse.

On each start-of-frame the scheduler looks only at the request at the head of the queue. It compares that request's parity select with the parity of the frame that is just beginning. On a match, the request leaves the queue and the token issuer emits one token per expected packet on consecutive cycles. On a mismatch the head stays in place and blocks everything behind it. A channel-disable strobe removes that channel's queued requests and cuts short a burst that belongs to it. A request that arrives with no room in the queue is dropped and raises a sticky overflow flag.

Top module: `prs_sched`

## Requirements
- R1: Each cycle with `en_wr` high that finds room appends exactly one request to the tail of the queue, and every stored request is dispatched at most once.
- R2: The queue holds at most QDEPTH (default 4) requests. A write that finds no room is discarded and sets `ovf_flag`, which stays at 1 until reset.
- R3: `frame_num` is an 11-bit count that goes up by one on each cycle with `sof` high, wraps from 2047 to 0 and is otherwise unchanged.
- R4: On a `sof` cycle the head request is dispatched only if bit 0 of the new frame number (`frame_num`+1) equals the request's `en_odd` value (1 = odd frame, 0 = even frame).
- R5: Only the head request is examined. A head of the wrong parity stays queued, and later requests wait behind it even if their parity matches.
- R6: A dispatched request drives `tok_valid` high for N consecutive cycles, starting the cycle after the `sof` edge. N is `en_mcnt` (2 bits, values 1 to 3), and the value 0 counts as 1. `tok_last` is high on the final token only.
- R7: While `tok_valid` is high, `tok_ch`, `tok_ep` and `tok_dir_in` carry the channel, endpoint and direction (`en_dir_in`: 1 = IN) of the dispatched request.
- R8: A cycle with `dis_wr` high removes every queued request whose channel equals `dis_ch` and keeps the others in order. A head request of that channel is not dispatched in the same cycle. A running burst of that channel stops, so `tok_valid` is low from the next cycle.
- R9: Room for a write is judged after the same cycle's dispatch and flush removals. A write to a full queue in the same cycle as a dispatch is therefore accepted and does not set `ovf_flag`.
- R10: At most one request is dispatched per `sof`. A `sof` that arrives while a burst is running dispatches nothing, even if the head's parity matches.
- R11: After reset the queue is empty, `tok_valid` is 0, `frame_num` is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Channel enable strobe, one request per cycle high |
| en_ch | input | 3 | Channel index of the request |
| en_ep | input | 4 | Endpoint number of the request |
| en_dir_in | input | 1 | Direction, 1 = IN |
| en_odd | input | 1 | Frame parity select, 1 = odd frame |
| en_mcnt | input | 2 | Packets per frame, 0 treated as 1 |
| dis_wr | input | 1 | Channel disable strobe |
| dis_ch | input | 3 | Channel to flush |
| sof | input | 1 | Start-of-frame pulse |
| tok_valid | output | 1 | Token request this cycle |
| tok_ch | output | 3 | Channel of the token |
| tok_ep | output | 4 | Endpoint of the token |
| tok_dir_in | output | 1 | Direction of the token |
| tok_last | output | 1 | Final token of the burst |
| frame_num | output | 11 | Current frame number |
| ovf_flag | output | 1 | Sticky queue overflow flag |

## Verification
The two functions that can meet in one cycle are a queue pop from a start-of-frame dispatch and a push from an enable write. The bench fills the queue to four entries and raises `sof` and `en_wr` together. It then checks that `ovf_flag` stays low and that the extra request comes out last when the queue drains. A second pairing puts a channel disable in the same cycle as the `sof` that would dispatch that channel's head, and one cycle into a running burst. The bench judges both by the count of `tok_valid` cycles seen at the ports.

// File: rtl/prs_pkg.sv
package prs_pkg;

  localparam int CH_W    = 3;
  localparam int EP_W    = 4;
  localparam int MC_W    = 2;
  localparam int FRAME_W = 11;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic [EP_W-1:0] ep;
    logic            dir_in;
    logic            odd;
    logic [MC_W-1:0] mcnt;
  } prs_req_t;

  // number of tokens a request expands to; a zero count still yields one
  function automatic logic [MC_W-1:0] tokens_for(input logic [MC_W-1:0] mc);
    return (mc == '0) ? MC_W'(1) : mc;
  endfunction

  // true when the frame about to begin has the parity the request asks for
  function automatic logic parity_hit(input logic cur_lsb, input logic want_odd);
    return (~cur_lsb) == want_odd;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_after(input logic [FRAME_W-1:0] f);
    return f + FRAME_W'(1);
  endfunction

endpackage

// File: rtl/prs_frame_ctr.sv
module prs_frame_ctr
  import prs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof,
  output logic [FRAME_W-1:0] frame_num
);

  always_ff @(posedge clk) begin
    if (!rst_n)   frame_num <= '0;
    else if (sof) frame_num <= frame_after(frame_num);
  end

endmodule

// File: rtl/prs_req_queue.sv
module prs_req_queue
  import prs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  prs_req_t                     push_req,
  input  logic                         pop,
  input  logic                         flush,
  input  logic [CH_W-1:0]              flush_ch,
  output prs_req_t                     head,
  output logic                         head_vld,
  output logic                         accept,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf
);

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  prs_req_t             slot    [DEPTH];
  prs_req_t             slot_nx [DEPTH];
  logic [CNT_W-1:0]     count_nx;
  int unsigned          fill;

  // compaction: drop popped and flushed entries, close the gaps in order,
  // then place an incoming request at the first free position
  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_nx[i] = slot[i];
    fill = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((i < int'(count)) && !(pop && (i == 0)) &&
          !(flush && (slot[i].ch == flush_ch))) begin
        slot_nx[fill[IDX_W-1:0]] = slot[i];
        fill = fill + 1;
      end
    end
    accept = push && (fill < DEPTH);
    if (accept) slot_nx[fill[IDX_W-1:0]] = push_req;
    count_nx = CNT_W'(fill + (accept ? 1 : 0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= slot_nx[i];
      count <= count_nx;
      if (push && !accept) ovf <= 1'b1;
    end
  end

  assign head     = slot[0];
  assign head_vld = (count != '0);

endmodule

// File: rtl/prs_token_issuer.sv
module prs_token_issuer
  import prs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_ch,
  input  logic [EP_W-1:0] load_ep,
  input  logic            load_dir,
  input  logic [MC_W-1:0] load_cnt,
  input  logic            cancel,
  input  logic [CH_W-1:0] cancel_ch,
  output logic            tok_valid,
  output logic [CH_W-1:0] tok_ch,
  output logic [EP_W-1:0] tok_ep,
  output logic            tok_dir_in,
  output logic            tok_last
);

  logic [MC_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain     <= '0;
      tok_ch     <= '0;
      tok_ep     <= '0;
      tok_dir_in <= 1'b0;
    end else if (load) begin
      remain     <= load_cnt;
      tok_ch     <= load_ch;
      tok_ep     <= load_ep;
      tok_dir_in <= load_dir;
    end else if (cancel && (tok_ch == cancel_ch) && (remain != '0)) begin
      remain <= '0;
    end else if (remain != '0) begin
      remain <= remain - MC_W'(1);
    end
  end

  assign tok_valid = (remain != '0);
  assign tok_last  = (remain == MC_W'(1));

endmodule

// File: rtl/prs_sched.sv
module prs_sched
  import prs_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [CH_W-1:0]    en_ch,
  input  logic [EP_W-1:0]    en_ep,
  input  logic               en_dir_in,
  input  logic               en_odd,
  input  logic [MC_W-1:0]    en_mcnt,
  input  logic               dis_wr,
  input  logic [CH_W-1:0]    dis_ch,
  input  logic               sof,
  output logic               tok_valid,
  output logic [CH_W-1:0]    tok_ch,
  output logic [EP_W-1:0]    tok_ep,
  output logic               tok_dir_in,
  output logic               tok_last,
  output logic [FRAME_W-1:0] frame_num,
  output logic               ovf_flag
);

  localparam int CNT_W = $clog2(QDEPTH+1);

  prs_req_t         new_req;
  prs_req_t         head;
  logic             head_vld;
  logic             head_odd;
  logic             head_flush;
  logic             q_push_ok;
  logic [CNT_W-1:0] q_count;
  logic             dispatch;

  assign new_req = '{ch: en_ch, ep: en_ep, dir_in: en_dir_in, odd: en_odd, mcnt: en_mcnt};

  prs_frame_ctr u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .frame_num (frame_num)
  );

  // named events for the checker
  assign head_odd   = head.odd;
  assign head_flush = dis_wr && (head.ch == dis_ch);
  assign dispatch   = sof && head_vld && !tok_valid && !head_flush &&
                      parity_hit(frame_num[0], head.odd);

  prs_req_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (en_wr),
    .push_req (new_req),
    .pop      (dispatch),
    .flush    (dis_wr),
    .flush_ch (dis_ch),
    .head     (head),
    .head_vld (head_vld),
    .accept   (q_push_ok),
    .count    (q_count),
    .ovf      (ovf_flag)
  );

  prs_token_issuer u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (dispatch),
    .load_ch    (head.ch),
    .load_ep    (head.ep),
    .load_dir   (head.dir_in),
    .load_cnt   (tokens_for(head.mcnt)),
    .cancel     (dis_wr),
    .cancel_ch  (dis_ch),
    .tok_valid  (tok_valid),
    .tok_ch     (tok_ch),
    .tok_ep     (tok_ep),
    .tok_dir_in (tok_dir_in),
    .tok_last   (tok_last)
  );

endmodule

// File: rtl/prs_sched_chk.sv
module prs_sched_chk
  import prs_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sof,
  input logic                         dis_wr,
  input logic [CH_W-1:0]              dis_ch,
  input logic                         tok_valid,
  input logic                         tok_last,
  input logic [CH_W-1:0]              tok_ch,
  input logic [FRAME_W-1:0]           frame_num,
  input logic                         ovf_flag,
  input logic                         dispatch,
  input logic                         head_odd,
  input logic                         q_push_ok,
  input logic [$clog2(QDEPTH+1)-1:0]  q_count
);

  localparam int CNT_W = $clog2(QDEPTH+1);

  a_r3_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> frame_num == FRAME_W'($past(frame_num) + FRAME_W'(1)));

  a_r3_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(frame_num));

  a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(QDEPTH));

  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    q_push_ok && !dispatch && !dis_wr |=> q_count == CNT_W'($past(q_count) + CNT_W'(1)));

  a_r4_parity_match: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> sof && (frame_num[0] != head_odd));

  a_r10_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> !tok_valid);

  a_r6_burst_start: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> tok_valid);

  a_r6_burst_run: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_last && !(dis_wr && (dis_ch == tok_ch)) |=> tok_valid);

  a_r6_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_last |=> !tok_valid);

  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_last |=> !tok_valid || $stable(tok_ch));

  a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && dis_wr && (dis_ch == tok_ch) |=> !tok_valid);

endmodule

bind prs_sched prs_sched_chk #(.QDEPTH(QDEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sof       (sof),
  .dis_wr    (dis_wr),
  .dis_ch    (dis_ch),
  .tok_valid (tok_valid),
  .tok_last  (tok_last),
  .tok_ch    (tok_ch),
  .frame_num (frame_num),
  .ovf_flag  (ovf_flag),
  .dispatch  (dispatch),
  .head_odd  (head_odd),
  .q_push_ok (q_push_ok),
  .q_count   (q_count)
);

// File: tb/prs_sched_tb.sv
`timescale 1ns/1ps
module prs_sched_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_wr = 1'b0;
  logic [2:0]  en_ch = '0;
  logic [3:0]  en_ep = '0;
  logic        en_dir_in = 1'b0;
  logic        en_odd = 1'b0;
  logic [1:0]  en_mcnt = '0;
  logic        dis_wr = 1'b0;
  logic [2:0]  dis_ch = '0;
  logic        sof = 1'b0;
  logic        tok_valid;
  logic [2:0]  tok_ch;
  logic [3:0]  tok_ep;
  logic        tok_dir_in;
  logic        tok_last;
  logic [10:0] frame_num;
  logic        ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int frame_m  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  prs_sched dut_i (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_ch(en_ch), .en_ep(en_ep),
    .en_dir_in(en_dir_in), .en_odd(en_odd), .en_mcnt(en_mcnt),
    .dis_wr(dis_wr), .dis_ch(dis_ch), .sof(sof),
    .tok_valid(tok_valid), .tok_ch(tok_ch), .tok_ep(tok_ep),
    .tok_dir_in(tok_dir_in), .tok_last(tok_last),
    .frame_num(frame_num), .ovf_flag(ovf_flag)
  );

  // request word: {ch[2:0], ep[3:0], dir, odd, mcnt[1:0]}
  function automatic logic [10:0] enc(int ch, int ep, int dir, int odd, int mc);
    return {3'(ch), 4'(ep), 1'(dir), 1'(odd), 2'(mc)};
  endfunction

  function automatic int burst_len(int mc);
    if (mc > 0) return mc;
    return 1;
  endfunction

  localparam logic [10:0] VEC [8] = '{
    11'b001_0010_1_1_01, 11'b010_0101_1_1_10, 11'b011_1001_0_0_11,
    11'b100_1111_1_0_00, 11'b101_0001_1_1_11, 11'b110_0000_1_0_10,
    11'b111_0111_0_1_00, 11'b000_1100_1_1_01
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_fields(input logic [10:0] w);
    en_ch = w[10:8]; en_ep = w[7:4]; en_dir_in = w[3]; en_odd = w[2]; en_mcnt = w[1:0];
  endtask

  task automatic wr_req(input logic [10:0] w);
    @(negedge clk); en_wr = 1'b1; put_fields(w);
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; frame_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one start-of-frame with an optional write and disable, then a
  // six-cycle window counting tokens
  task automatic sof_win(input bit do_wr, input logic [10:0] w, input bit do_dis,
                         input bit dis_late, input int dch,
                         output int n, output int ch0, output int ep0,
                         output int dir0, output int lastok);
    int lastcnt;
    int lastpos;
    @(negedge clk);
    sof = 1'b1;
    if (do_wr) begin en_wr = 1'b1; put_fields(w); end
    if (do_dis && !dis_late) begin dis_wr = 1'b1; dis_ch = 3'(dch); end
    @(negedge clk);
    sof = 1'b0; en_wr = 1'b0; dis_wr = 1'b0;
    if (do_dis && dis_late) begin dis_wr = 1'b1; dis_ch = 3'(dch); end
    frame_m = (frame_m + 1) % 2048;
    n = 0; ch0 = -1; ep0 = -1; dir0 = -1; lastcnt = 0; lastpos = -1;
    for (int k = 0; k < 6; k++) begin
      if (tok_valid) begin
        if (n == 0) begin ch0 = tok_ch; ep0 = tok_ep; dir0 = tok_dir_in; end
        if (tok_last) begin lastcnt++; lastpos = n; end
        n++;
      end
      @(negedge clk);
      if (k == 0) dis_wr = 1'b0;
    end
    lastok = (n == 0) ? int'(lastcnt == 0) : int'(lastcnt == 1 && lastpos == n - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n, c0, e0, d0, lok, pe, cnt, lastc;
    logic [10:0] w;
    do_reset();
    @(negedge clk);
    check("R11 reset tok_valid", int'(tok_valid), 0);
    check("R11 reset frame_num", int'(frame_num), 0);
    check("R11 reset ovf_flag", int'(ovf_flag), 0);

    // table walk: R1 R4 R6 R7
    foreach (VEC[i]) begin
      w = VEC[i];
      wr_req(w);
      pe = (frame_m + 1) % 2;
      sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
      if (pe != int'(w[2])) begin
        check("R4 mismatched parity holds request", n, 0);
        sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
      end
      check("R6 token count", n, burst_len(int'(w[1:0])));
      check("R6 tok_last on final token", lok, 1);
      check("R7 tok_ch", c0, int'(w[10:8]));
      check("R7 tok_ep", e0, int'(w[7:4]));
      check("R7 tok_dir_in", d0, int'(w[3]));
      check("R3 frame_num tracks sof", int'(frame_num), frame_m);
    end

    // R5 head blocking
    pe = (frame_m + 1) % 2;
    wr_req(enc(1, 3, 1, 1 - pe, 1));
    wr_req(enc(2, 4, 1, pe, 2));
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R5 matching entry blocked behind head", n, 0);
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R5 head issues first", c0, 1);
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R5 second entry follows", c0, 2);
    check("R5 second entry count", n, 2);

    // R8 flush of queued entries
    pe = (frame_m + 1) % 2;
    wr_req(enc(3, 1, 1, pe, 1));
    wr_req(enc(5, 2, 1, pe, 1));
    wr_req(enc(3, 3, 1, pe, 1));
    @(negedge clk); dis_wr = 1'b1; dis_ch = 3'd3;
    @(negedge clk); dis_wr = 1'b0;
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R8 survivor of flush issues", c0, 5);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
      cnt += n;
    end
    check("R8 flushed entries never issue", cnt, 0);

    // R8 burst cancelled one cycle after dispatch
    pe = (frame_m + 1) % 2;
    wr_req(enc(6, 6, 1, pe, 3));
    sof_win(1'b0, '0, 1'b1, 1'b1, 6, n, c0, e0, d0, lok);
    check("R8 running burst cut short", n, 1);

    // R8 head flushed on its own sof cycle
    pe = (frame_m + 1) % 2;
    wr_req(enc(4, 2, 1, pe, 2));
    sof_win(1'b0, '0, 1'b1, 1'b0, 4, n, c0, e0, d0, lok);
    check("R8 flushed head not dispatched", n, 0);
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R8 flushed head gone later", n, 0);

    // R10 sof during a burst dispatches nothing
    pe = (frame_m + 1) % 2;
    wr_req(enc(2, 9, 1, pe, 3));
    wr_req(enc(7, 5, 1, 1 - pe, 1));
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0; cnt = int'(tok_valid);
    sof = 1'b1;
    @(negedge clk); sof = 1'b0; cnt += int'(tok_valid);
    frame_m = (frame_m + 2) % 2048;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); cnt += int'(tok_valid);
    end
    check("R10 only first burst tokens", cnt, 3);
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R10 waiting entry still on parity", n, 0);
    sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R10 entry kept and issued later", c0, 7);

    // R2 overflow
    check("R2 ovf_flag low before overflow", int'(ovf_flag), 0);
    pe = (frame_m + 1) % 2;
    for (int k = 0; k < 5; k++) wr_req(enc(k, k, 1, pe, 1));
    check("R2 ovf_flag set on fifth write", int'(ovf_flag), 1);
    cnt = 0; lastc = -1;
    for (int k = 0; k < 10; k++) begin
      sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
      if (n > 0) begin
        check("R1 queue order", c0, cnt);
        cnt++; lastc = c0;
      end
    end
    check("R2 only four requests kept", cnt, 4);
    check("R2 dropped request absent", lastc, 3);
    check("R2 ovf_flag sticky", int'(ovf_flag), 1);

    // R9 push into full queue during dispatch
    do_reset();
    for (int k = 0; k < 4; k++) wr_req(enc(k, 1, 1, 1, 1));
    sof_win(1'b1, enc(7, 2, 1, 1, 1), 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
    check("R9 head dispatched with push", c0, 0);
    check("R9 no overflow on push during pop", int'(ovf_flag), 0);
    cnt = 0; lastc = -1;
    for (int k = 0; k < 8; k++) begin
      sof_win(1'b0, '0, 1'b0, 1'b0, 0, n, c0, e0, d0, lok);
      if (n > 0) begin cnt++; lastc = c0; end
    end
    check("R9 remaining dispatches", cnt, 4);
    check("R9 pushed request issues last", lastc, 7);

    // R3 wrap
    do_reset();
    for (int k = 0; k < 2047; k++) begin
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
    end
    check("R3 frame_num at top", int'(frame_num), 2047);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    check("R3 frame_num wraps to zero", int'(frame_num), 0);
    check("R3 no tokens with empty queue", int'(tok_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule